// File: doc/BRIEF.md
# Serial Gain Register Slave

This block is the digital side of a three-wire control port. A host lowers a frame strobe, clocks a header and data bits in on a serial clock, and raises the strobe again. The block keeps one 10-bit gain word, which drives a gain stage outside this block, and it can shift that word back out on the same port. Each frame opens with a direction bit, 0 for a write and 1 for a read, followed by four address bits. A write only takes effect when the strobe rises. A read places the stored word on the data line, one bit per falling clock edge.

The serial pins change slowly compared with the system clock. They pass through a synchronizer chain, and every action inside the block is taken on an edge detected in the system-clock domain. The data line is split into an input, an output and an output enable, and the pad sits outside the block. After each reset, writes are locked out for a number of system-clock cycles that is set by a parameter, so that the analog calibration can finish first. Reads work during that window.

Top module: `tw_gain_slave`

## Requirements
- R1: While `rst` is high, and once it falls, `gain` holds 10'h096 and `sdo_oe` is low.
- R2: A write frame has these bits in order. First comes the direction bit, 0 for a write. Next come the address bits 0,0,1,0, the first-sent bit being the address MSB. Last come the data bits, least significant first. If a write frame delivers at least 10 data bits, then after the strobe rises `gain` equals the first 10 data bits.
- R3: `gain` changes only on a rising edge of the strobe. While `sl` stays low it keeps its old value, even after every data bit has been clocked in.
- R4: An 11th data bit is counted but never stored. On readback the 11th data slot is driven as 0.
- R5: A frame whose address is not 0,0,1,0 leaves `gain` unchanged and never raises `sdo_oe`.
- R6: A write frame with fewer than 10 data bits leaves `gain` unchanged. A write frame with exactly 10 data bits is committed.
- R7: On a read frame (direction bit 1, address 0,0,1,0), `sdo_oe` rises after the 5th falling edge of `sck`. `sdo` then carries D0, and each later falling edge advances it by one bit, up to D9.
- R8: `sdo_oe` is high only during the data phase of a matched read. It drops once `sl` returns high, and `sdo` is 0 whenever `sdo_oe` is low.
- R9: For LOCKOUT_CYCLES system-clock cycles after `rst` falls, write frames leave `gain` unchanged. After that window, writes are accepted again.
- R10: A commit or enable release caused by the rise of `sl` becomes visible at the SYNC_STAGES+1-th rising edge of `clk` after the pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all serial pins |
| rst | input | 1 | Synchronous active-high chip reset |
| sck | input | 1 | Serial clock from the host, idles low |
| sl | input | 1 | Frame strobe, high when idle, low for a frame |
| sdi | input | 1 | Serial data from the host (input side of the data pad) |
| sdo | output | 1 | Serial readback data (output side of the data pad) |
| sdo_oe | output | 1 | Drive enable for the data pad |
| gain | output | 10 | Current gain word for the analog stage |

## Verification
Each serial pin passes through SYNC_STAGES synchronizer flops and one edge-detect flop, and the action then registers. So `gain` and the release of `sdo_oe` settle at the third rising `clk` edge after `sl` rises, with the default depth. `sdo` and the rise of `sdo_oe` settle at the third edge after an `sck` fall. The bench holds each serial level for eight system cycles and samples on falling `clk` edges. It reads `gain` exactly SYNC_STAGES+1 cycles after it raises `sl`, which checks the R10 latency. It reads `sdo` eight cycles after each `sck` fall. It also checks `gain` just before `sl` rises, to confirm that nothing committed early.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int HDR_BITS   = 5;
    localparam int ADDR_W     = 4;
    localparam int GAIN_W     = 10;
    localparam int DATA_SLOTS = 11;
    localparam int FRAME_BITS = HDR_BITS + DATA_SLOTS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [ADDR_W-1:0] GAIN_ADDR    = 4'b0010;
    localparam logic [GAIN_W-1:0] GAIN_DEFAULT = 10'h096;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic              rnw;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic lvl;
    } pin_ev_t;

    function automatic logic hdr_hit(hdr_t h, logic want_read);
        return (h.addr == GAIN_ADDR) && (h.rnw == want_read);
    endfunction

endpackage

// File: rtl/tw_pin_sync.sv
module tw_pin_sync
    import tw_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    pin,
    output pin_ev_t ev
);

    logic [STAGES-1:0] chain;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= RST_VAL;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= RST_VAL;
        else     last_q <= chain[STAGES-1];
    end

    always_comb begin
        ev.lvl  = chain[STAGES-1];
        ev.rise = chain[STAGES-1] & ~last_q;
        ev.fall = ~chain[STAGES-1] & last_q;
    end

endmodule

// File: rtl/tw_frame_dec.sv
module tw_frame_dec
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_ev_t           sl_ev,
    input  pin_ev_t           sck_ev,
    input  logic              sdi_lvl,
    output logic [GAIN_W-1:0] wr_value,
    output logic              wr_commit,
    output logic              rd_load,
    output logic              rd_step
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0]  rise_cnt;
    logic [CNT_W-1:0]  fall_cnt;
    logic [CNT_W-1:0]  slot_idx;
    hdr_t              hdr;
    logic [GAIN_W-1:0] data_sr;
    phase_t            phase;

    assign slot_idx = rise_cnt - CNT_W'(HDR_BITS);

    always_comb begin
        if (sl_ev.lvl)                          phase = PH_IDLE;
        else if (rise_cnt < CNT_W'(HDR_BITS))   phase = PH_HDR;
        else                                    phase = PH_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst || sl_ev.fall) begin
            rise_cnt <= '0;
            fall_cnt <= '0;
            hdr      <= '0;
            data_sr  <= '0;
        end else if (phase != PH_IDLE) begin
            if (sck_ev.rise && rise_cnt != CNT_MAX) begin
                rise_cnt <= rise_cnt + 1'b1;
                if (phase == PH_HDR) begin
                    hdr <= {hdr[HDR_BITS-2:0], sdi_lvl};
                end else begin
                    for (int k = 0; k < GAIN_W; k++) begin
                        if (slot_idx == CNT_W'(k)) data_sr[k] <= sdi_lvl;
                    end
                end
            end
            if (sck_ev.fall && fall_cnt != CNT_MAX) begin
                fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    assign wr_value  = data_sr;
    assign wr_commit = sl_ev.rise
                     && (rise_cnt >= CNT_W'(HDR_BITS + GAIN_W))
                     && hdr_hit(hdr, 1'b0);
    assign rd_load   = sck_ev.fall && (phase == PH_DATA)
                     && (fall_cnt == CNT_W'(HDR_BITS - 1))
                     && hdr_hit(hdr, 1'b1);
    assign rd_step   = sck_ev.fall && (phase != PH_IDLE)
                     && (fall_cnt >= CNT_W'(HDR_BITS));

endmodule

// File: rtl/tw_gain_store.sv
module tw_gain_store
    import tw_pkg::*;
#(
    parameter int LOCKOUT_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [GAIN_W-1:0] value,
    output logic [GAIN_W-1:0] gain,
    output logic              lock_done
);

    localparam int LOCK_W = $clog2(LOCKOUT_CYCLES + 1);
    localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCKOUT_CYCLES);

    logic [LOCK_W-1:0] lock_cnt;

    assign lock_done = (lock_cnt == LOCK_END);

    always_ff @(posedge clk) begin
        if (rst)             lock_cnt <= '0;
        else if (!lock_done) lock_cnt <= lock_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                       gain <= GAIN_DEFAULT;
        else if (commit && lock_done)  gain <= value;
    end

endmodule

// File: rtl/tw_readback.sv
module tw_readback
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sl_lvl,
    input  logic              rd_load,
    input  logic              rd_step,
    input  logic [GAIN_W-1:0] gain,
    output logic              sdo,
    output logic              sdo_oe
);

    logic [DATA_SLOTS-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst || sl_lvl) begin
            sdo_oe <= 1'b0;
            out_sr <= '0;
        end else if (rd_load) begin
            sdo_oe <= 1'b1;
            out_sr <= {{(DATA_SLOTS-GAIN_W){1'b0}}, gain};
        end else if (rd_step && sdo_oe) begin
            out_sr <= out_sr >> 1;
        end
    end

    assign sdo = sdo_oe & out_sr[0];

endmodule

// File: rtl/tw_gain_slave.sv
module tw_gain_slave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int LOCKOUT_CYCLES = 5000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sck,
    input  logic        sl,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    output logic [9:0]  gain
);

    pin_ev_t           sl_ev;
    pin_ev_t           sck_ev;
    logic [SYNC_STAGES-1:0] sdi_chain;
    logic [GAIN_W-1:0] wr_value;
    logic              wr_commit;
    logic              rd_load;
    logic              rd_step;
    logic              lock_done;
    logic              sl_lvl;
    logic              sl_rise;
    logic              sck_fall;

    tw_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sl_sync (
        .clk(clk), .rst(rst), .pin(sl), .ev(sl_ev)
    );

    tw_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .pin(sck), .ev(sck_ev)
    );

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sdi
            always_ff @(posedge clk) begin
                if (rst)         sdi_chain[g] <= 1'b0;
                else if (g == 0) sdi_chain[g] <= sdi;
                else             sdi_chain[g] <= sdi_chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    tw_frame_dec u_dec (
        .clk(clk), .rst(rst),
        .sl_ev(sl_ev), .sck_ev(sck_ev), .sdi_lvl(sdi_chain[SYNC_STAGES-1]),
        .wr_value(wr_value), .wr_commit(wr_commit),
        .rd_load(rd_load), .rd_step(rd_step)
    );

    tw_gain_store #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_store (
        .clk(clk), .rst(rst),
        .commit(wr_commit), .value(wr_value),
        .gain(gain), .lock_done(lock_done)
    );

    tw_readback u_rb (
        .clk(clk), .rst(rst),
        .sl_lvl(sl_ev.lvl), .rd_load(rd_load), .rd_step(rd_step),
        .gain(gain), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    assign sl_lvl   = sl_ev.lvl;
    assign sl_rise  = sl_ev.rise;
    assign sck_fall = sck_ev.fall;

endmodule

// File: rtl/tw_gain_slave_chk.sv
module tw_gain_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       sl_lvl,
    input logic       sl_rise,
    input logic       sck_fall,
    input logic       lock_done,
    input logic       sdo,
    input logic       sdo_oe,
    input logic [9:0] gain
);

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        rst |=> (gain == 10'h096 && !sdo_oe)); // R1

    AST_GAIN_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (rst)
        !sl_rise |=> $stable(gain)); // R3

    AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !lock_done |=> $stable(gain)); // R9

    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        sl_lvl |=> !sdo_oe); // R8

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo); // R8

    AST_OE_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(sck_fall)); // R7

endmodule

bind tw_gain_slave tw_gain_slave_chk chk_i (
    .clk(clk), .rst(rst), .sl_lvl(sl_lvl), .sl_rise(sl_rise),
    .sck_fall(sck_fall), .lock_done(lock_done),
    .sdo(sdo), .sdo_oe(sdo_oe), .gain(gain)
);

// File: tb/tw_gain_slave_tb_top.sv
module tw_gain_slave_tb_top;

    localparam int SYNC = 2;
    localparam int LOCK = 5000;
    localparam int H    = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       sl  = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_oe;
    logic [9:0] gain;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    int unsigned cyc    = 0;
    logic [9:0]  exp_gain = 10'h096;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    tw_gain_slave #(.SYNC_STAGES(SYNC), .LOCKOUT_CYCLES(LOCK)) dut_i (
        .clk(clk), .rst(rst), .sck(sck), .sl(sl), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .gain(gain)
    );

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic addr_ok(input logic [3:0] a);
        return a == 4'b0010;
    endfunction

    function automatic logic write_takes(input logic rnw, input logic [3:0] a,
                                         input int nb, input logic unlocked);
        return !rnw && addr_ok(a) && nb >= 10 && unlocked;
    endfunction

    task automatic run_frame(input logic rnw, input logic [3:0] a,
                             input logic [10:0] d, input int nb, input string req);
        logic [9:0]  old;
        logic [10:0] rd;
        logic        drv;
        logic        take;
        int          oe_bad;
        old    = exp_gain;
        drv    = rnw && addr_ok(a);
        rd     = '0;
        oe_bad = 0;
        sl = 1'b0;
        waitc(H);
        for (int i = 0; i < 5 + nb; i++) begin
            if (i == 0)     sdi = rnw;
            else if (i < 5) sdi = a[4-i];
            else            sdi = d[i-5];
            waitc(H);
            sck = 1'b1;
            waitc(H);
            sck = 1'b0;
            waitc(H);
            if (sdo_oe !== (drv && (i + 1) >= 5)) oe_bad++;
            if ((i + 1) >= 5 && (i + 1) <= 15) rd[i-4] = sdo;
        end
        chk(gain === old, "R3 gain before strobe rise", int'(gain), int'(old));
        sl = 1'b1;
        take = write_takes(rnw, a, nb, cyc >= LOCK + 2);
        waitc(SYNC + 1);
        if (take) exp_gain = d[9:0];
        chk(gain === exp_gain, {req, " R10 gain after strobe"}, int'(gain), int'(exp_gain));
        chk(sdo_oe === 1'b0, "R8 enable released", int'(sdo_oe), 0);
        chk(oe_bad == 0, drv ? "R7 enable timing" : "R5 no drive", oe_bad, 0);
        if (drv && nb >= 11)
            chk(rd === {1'b0, old}, "R7 R4 readback bits", int'(rd), int'({1'b0, old}));
        waitc(H);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sl  = 1'b1;
        sck = 1'b0;
        waitc(4);
        chk(gain === 10'h096 && sdo_oe === 1'b0, "R1 during reset", int'(gain), 'h096);
        rst = 1'b0;
        exp_gain = 10'h096;
        waitc(2);
        chk(gain === 10'h096 && sdo_oe === 1'b0, "R1 after reset", int'(gain), 'h096);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R9: write inside the lockout window is dropped
        run_frame(1'b0, 4'b0010, 11'h155, 11, "R9 locked write");
        // R1/R7: default visible through readback
        run_frame(1'b1, 4'b0010, 11'h000, 11, "R7 read default");
        waitc(LOCK);
        // R2/R4: full write with D10 set
        run_frame(1'b0, 4'b0010, 11'h7A5, 11, "R2 R4 write");
        run_frame(1'b1, 4'b0010, 11'h000, 11, "R7 read back");
        // R5: address mismatch, write and read
        run_frame(1'b0, 4'b0011, 11'h0F0, 11, "R5 wrong addr write");
        run_frame(1'b1, 4'b1010, 11'h000, 11, "R5 wrong addr read");
        // R6: short write ignored, exact 10 bits taken
        run_frame(1'b0, 4'b0010, 11'h0AA, 9, "R6 short write");
        run_frame(1'b0, 4'b0010, 11'h2C3, 10, "R6 ten-bit write");
        run_frame(1'b1, 4'b0010, 11'h000, 11, "R7 read ten-bit");
        for (int n = 0; n < 40; n++) begin
            logic       r;
            logic [3:0] a;
            logic [10:0] d;
            int         nb;
            r  = 1'($urandom % 2);
            a  = ($urandom % 4 != 0) ? 4'b0010 : 4'($urandom % 16);
            d  = 11'($urandom);
            nb = ($urandom % 5 == 0) ? int'($urandom % 12) : 11;
            run_frame(r, a, d, nb, "R2 random");
        end
        // R1/R9: second reset restores default and re-arms lockout
        do_reset();
        run_frame(1'b0, 4'b0010, 11'h3FF, 11, "R9 relocked write");
        waitc(LOCK);
        run_frame(1'b0, 4'b0010, 11'h001, 11, "R9 write after window");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule